// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps a pending flag and a mask flag for each of a set of interrupt sources. It also decides which pending source the processor takes. A one-cycle pulse from a source, such as an edge detector or a counter wrap, marks that source as pending. The processor raises a sample strobe at each instruction boundary. At that clock edge, and only then, the block looks at every pending flag and every mask flag, and at a global disable input.

When at least one source is both pending and unmasked, and the disable input is low, the block picks the lowest-numbered such source. In the next cycle it presents a single-cycle grant pulse with the winner's number. It clears that source's pending flag at the same edge. Sources that lose keep their pending flags and take part again at the next sample strobe.

A small register port lets software read both flag sets and write them. A write to the pending set can only clear flags. A write to the mask set replaces the whole mask.

Top module: `intreq_ctrl`

## Requirements
- R1: A high bit on `src_pulse` at a clock edge sets the pending flag of that source. The flag reads back as 1 in the pending set (`reg_sel` = 0) from the next cycle.
- R2: A source can be granted only when its pending flag is 1, its mask flag is 1 and `int_disable` is 0 at the sampling edge. If any of the three fails, no grant is produced for that source.
- R3: Arbitration takes place only at a clock edge where `accept_pt` is 1. With `accept_pt` at 0, no grant pulse appears, however many sources are pending and unmasked.
- R4: When several sources qualify at the same sampling edge, only the one with the smallest index is granted. Index 0 has the highest priority.
- R5: Pending flags of sources that are not granted stay unchanged through a sampling edge, and they are considered again at the next one.
- R6: At the sampling edge that grants a source, that source's pending flag is cleared.
- R7: If a source pulse arrives at the same edge that clears that source's pending flag, the flag stays set.
- R8: A write with `reg_sel` = 0 clears every pending flag whose data bit is 0, and leaves every pending flag whose data bit is 1 unchanged.
- R9: `acc_strobe` is high for exactly the one cycle after the sampling edge that made a grant, with `acc_index` giving the winner in that cycle. While `acc_strobe` is low, `acc_index` is 0.
- R10: After reset, all pending flags and all mask flags are 0, `acc_strobe` is 0 and `acc_index` is 0.
- R11: A write with `reg_sel` = 1 loads the mask flags from `reg_wdata`. Reading with `reg_sel` = 1 returns the mask flags on `reg_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | NSRC | Event pulses from the sources, one bit each |
| accept_pt | input | 1 | Instruction-boundary sample strobe from the processor |
| int_disable | input | 1 | Global disable flag; when 1, nothing is granted |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 pending set, 1 mask set |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Read data for the selected set, combinational |
| acc_strobe | output | 1 | One-cycle grant pulse |
| acc_index | output | IW | Index of the granted source, 0 while idle |

## Verification
The hardest case to reach from the ports is a source pulse that lands on the very edge at which that same source is granted and cleared. The bench first marks the source pending with an earlier pulse. It then raises the sample strobe and the same source's pulse in one driven cycle. Afterwards it checks that the grant appeared and that the pending flag still reads 1. Priority is exercised with pending sets that mix masked and unmasked sources, so that the winner is not simply the lowest pending bit.

// File: rtl/intreq_pkg.sv
package intreq_pkg;

  // register select encoding on the software port
  typedef enum logic {
    SEL_PEND = 1'b0,
    SEL_MASK = 1'b1
  } intreq_sel_e;

  // index width for a given source count
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/intreq_pend_bank.sv
module intreq_pend_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] grant_vec,
  input  logic            sw_clr,
  input  logic [NSRC-1:0] sw_keep,
  output logic [NSRC-1:0] pend_q
);

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_bit
      logic clr_bit;
      assign clr_bit = grant_vec[gi] | (sw_clr & ~sw_keep[gi]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pend_q[gi] <= 1'b0;
        else if (set_vec[gi])    pend_q[gi] <= 1'b1;
        else if (clr_bit)        pend_q[gi] <= 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/intreq_mask_bank.sv
module intreq_mask_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NSRC-1:0] load_val,
  output logic [NSRC-1:0] mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (load) mask_q <= load_val;
  end

endmodule

// File: rtl/intreq_picker.sv
module intreq_picker #(
  parameter int NSRC = 8,
  localparam int IW = intreq_pkg::idx_width(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic [NSRC-1:0] onehot,
  output logic [IW-1:0]   index,
  output logic            any
);

  logic [NSRC:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_chain
      assign onehot[gi]  = cand[gi] & ~seen[gi];
      assign seen[gi+1]  = seen[gi] | cand[gi];
    end
  endgenerate

  assign any = seen[NSRC];

  always_comb begin
    index = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (onehot[i]) index = index | IW'(i);
    end
  end

endmodule

// File: rtl/intreq_ctrl.sv
module intreq_ctrl #(
  parameter int NSRC = 8,
  localparam int IW = intreq_pkg::idx_width(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic            accept_pt,
  input  logic            int_disable,
  input  logic            reg_wr,
  input  logic            reg_sel,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            acc_strobe,
  output logic [IW-1:0]   acc_index
);
  import intreq_pkg::*;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] qual_vec;
  logic [NSRC-1:0] pick_vec;
  logic [NSRC-1:0] grant_vec;
  logic [IW-1:0]   pick_idx;
  logic            pick_any;
  logic            accept_fire;
  logic            wr_pend;
  logic            wr_mask;

  assign wr_pend = reg_wr & (reg_sel == SEL_PEND);
  assign wr_mask = reg_wr & (reg_sel == SEL_MASK);

  intreq_pend_bank #(.NSRC(NSRC)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (src_pulse),
    .grant_vec (grant_vec),
    .sw_clr    (wr_pend),
    .sw_keep   (reg_wdata),
    .pend_q    (pend_q)
  );

  intreq_mask_bank #(.NSRC(NSRC)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_mask),
    .load_val (reg_wdata),
    .mask_q   (mask_q)
  );

  assign qual_vec = pend_q & mask_q;

  intreq_picker #(.NSRC(NSRC)) u_pick (
    .cand   (qual_vec),
    .onehot (pick_vec),
    .index  (pick_idx),
    .any    (pick_any)
  );

  assign accept_fire = accept_pt & ~int_disable & pick_any;
  assign grant_vec   = accept_fire ? pick_vec : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_strobe <= 1'b0;
      acc_index  <= '0;
    end else begin
      acc_strobe <= accept_fire;
      acc_index  <= accept_fire ? pick_idx : '0;
    end
  end

  assign reg_rdata = (reg_sel == SEL_MASK) ? mask_q : pend_q;

endmodule

// File: rtl/intreq_ctrl_chk.sv
module intreq_ctrl_chk #(
  parameter int NSRC = 8,
  localparam int IW = intreq_pkg::idx_width(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_pulse,
  input logic            accept_pt,
  input logic            int_disable,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] grant_vec,
  input logic            acc_strobe,
  input logic [IW-1:0]   acc_index
);

  logic [NSRC-1:0] pend_prev;
  logic [NSRC-1:0] mask_prev;
  logic [NSRC-1:0] pulse_prev;
  logic [NSRC-1:0] above_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_prev  <= '0;
      mask_prev  <= '0;
      pulse_prev <= '0;
    end else begin
      pend_prev  <= pend_q;
      mask_prev  <= mask_q;
      pulse_prev <= src_pulse;
    end
  end

  assign above_mask = (NSRC'(1) << acc_index) - NSRC'(1);

  assert_grant_after_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> $past(accept_pt));

  assert_no_grant_without_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_pt |-> (grant_vec == '0));

  assert_grant_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> (!$past(int_disable) && pend_prev[acc_index] && mask_prev[acc_index]));

  assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> ((pend_prev & mask_prev & above_mask) == '0));

  assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));

  assert_winner_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe |-> (!pend_q[acc_index] || pulse_prev[acc_index]));

  assert_pulse_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pulse_prev & ~pend_q) == '0));

  assert_idle_index_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_strobe |-> (acc_index == '0));

endmodule

bind intreq_ctrl intreq_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_pulse   (src_pulse),
  .accept_pt   (accept_pt),
  .int_disable (int_disable),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .grant_vec   (grant_vec),
  .acc_strobe  (acc_strobe),
  .acc_index   (acc_index)
);

// File: tb/tb_intreq_ctrl.sv
module tb_intreq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src_pulse = '0;
  logic          accept_pt = 1'b0;
  logic          int_disable = 1'b0;
  logic          reg_wr = 1'b0;
  logic          reg_sel = 1'b0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          acc_strobe;
  logic [IW-1:0] acc_index;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intreq_ctrl #(.NSRC(N)) dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .accept_pt(accept_pt),
    .int_disable(int_disable), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_strobe(acc_strobe), .acc_index(acc_index)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic read_set(input logic sel, output logic [N-1:0] v);
    reg_sel = sel;
    #1;
    v = reg_rdata;
  endtask

  task automatic write_set(input logic sel, input logic [N-1:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    src_pulse = v;
    tick();
    src_pulse = '0;
  endtask

  // raise the sample strobe for one cycle, then check the grant outputs
  task automatic sample(input string req, input logic exp_stb, input logic [IW-1:0] exp_idx);
    accept_pt = 1'b1;
    tick();
    accept_pt = 1'b0;
    check({req, " strobe"}, 32'(acc_strobe), 32'(exp_stb));
    check({req, " index"}, 32'(acc_index), 32'(exp_idx));
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    check("R10 strobe", 32'(acc_strobe), 0);
    check("R10 index", 32'(acc_index), 0);
    read_set(1'b0, v); check("R10 pending", 32'(v), 0);
    read_set(1'b1, v); check("R10 mask", 32'(v), 0);
  endtask

  task automatic t_set_and_mask();
    logic [N-1:0] v;
    pulse(8'h08);
    read_set(1'b0, v); check("R1 pulse sets pending", 32'(v), 32'h08);
    write_set(1'b1, 8'hA5);
    read_set(1'b1, v); check("R11 mask readback", 32'(v), 32'hA5);
    write_set(1'b0, 8'h00);
  endtask

  task automatic t_no_point();
    logic [N-1:0] v;
    write_set(1'b1, 8'hFF);
    pulse(8'h11);
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R3 no strobe without sample point", 32'(acc_strobe), 0);
    end
    read_set(1'b0, v); check("R3 pending kept", 32'(v), 32'h11);
    write_set(1'b0, 8'h00);
  endtask

  task automatic t_gating();
    logic [N-1:0] v;
    write_set(1'b1, 8'hFF);
    pulse(8'h24);
    int_disable = 1'b1;
    sample("R2 disabled", 1'b0, '0);
    int_disable = 1'b0;
    read_set(1'b0, v); check("R5 pending kept while disabled", 32'(v), 32'h24);
    write_set(1'b1, 8'hDB);
    sample("R2 masked", 1'b0, '0);
    read_set(1'b0, v); check("R5 pending kept while masked", 32'(v), 32'h24);
    write_set(1'b1, 8'h20);
    sample("R2 masked low bit skipped", 1'b1, 3'd5);
    write_set(1'b0, 8'h00);
  endtask

  task automatic t_priority();
    logic [N-1:0] v;
    write_set(1'b1, 8'hFF);
    pulse(8'h28);
    sample("R4 lowest first", 1'b1, 3'd3);
    read_set(1'b0, v); check("R6 R5 winner cleared loser kept", 32'(v), 32'h20);
    tick();
    check("R9 strobe one cycle", 32'(acc_strobe), 0);
    check("R9 index idle zero", 32'(acc_index), 0);
    sample("R5 loser granted later", 1'b1, 3'd5);
    read_set(1'b0, v); check("R6 all cleared", 32'(v), 0);
    pulse(8'h81);
    sample("R4 index zero highest", 1'b1, 3'd0);
    sample("R4 next index seven", 1'b1, 3'd7);
  endtask

  task automatic t_set_wins();
    logic [N-1:0] v;
    write_set(1'b1, 8'hFF);
    pulse(8'h04);
    src_pulse = 8'h04;
    sample("R7 grant with pulse", 1'b1, 3'd2);
    src_pulse = '0;
    read_set(1'b0, v); check("R7 set wins over clear", 32'(v), 32'h04);
    write_set(1'b0, 8'h00);
  endtask

  task automatic t_sw_clear();
    logic [N-1:0] v;
    write_set(1'b1, 8'h00);
    pulse(8'hFF);
    write_set(1'b0, 8'hF0);
    read_set(1'b0, v); check("R8 zero bits clear", 32'(v), 32'hF0);
    write_set(1'b0, 8'hFF);
    read_set(1'b0, v); check("R8 one bits no effect", 32'(v), 32'hF0);
    write_set(1'b0, 8'h00);
    read_set(1'b0, v); check("R8 clear all", 32'(v), 0);
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_set_and_mask();
    t_no_point();
    t_gating();
    t_priority();
    t_set_wins();
    t_sw_clear();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule